// File: doc/BRIEF.md
# Vector Memory Transfer Sequencer

This block moves four-lane vectors of 24-bit words between a byte-wide, single-port memory and three vector registers, called A, S and T here. It also runs the arithmetic forms that take one operand from memory. In those forms, each lane of a vector read from memory is combined with the matching lane of register A, and the result always goes back into A. A caller supplies a resolved base address, an operation code and a register code, then pulses `start`. The sequencer then runs the byte accesses on its own and signals completion with a one-cycle `done` pulse.

A vector takes twelve consecutive bytes. It holds four 3-byte words, and each word is stored with its most significant byte at the lowest address. For a read, the memory returns data one cycle after the address is presented. Every read-type operation first collects all twelve bytes. Only after that does it update a register, in a single commit cycle. A divide with a zero in any memory lane writes nothing and raises the error flag.

Top module: `vecmem_sequencer`

## Requirements
- R1: While reset is high and right after it, `done`, `div_err` and `mem_we` are low, and all three vector registers hold zero in every lane.
- R2: Lane i of a vector sits at base+3i. Each word is big-endian, so the byte at the lowest address carries bits 23:16. Byte addresses wrap modulo 2^ADDR_W.
- R3: Operation code 0 (load) reads twelve bytes from base and replaces the register chosen by `reg_sel`. Code 0 selects A, 1 selects S, and 2 or 3 select T. The other registers keep their contents.
- R4: Operation code 1 (store) writes the twelve bytes of the selected register, one byte per cycle on consecutive addresses. `mem_we` is high only during those twelve cycles, and no other memory byte changes.
- R5: Codes 2 (add), 3 (subtract: A minus memory) and 4 (multiply, low 24 bits of the product) replace each lane of A with the result modulo 2^24. They ignore `reg_sel` and leave S and T unchanged.
- R6: Code 5 (divide) replaces each lane of A with the signed quotient A / memory, truncated toward zero and kept to 24 bits.
- R7: If any memory lane of a divide is zero, `div_err` is high in the `done` cycle and A is left unchanged. For every other operation, and for a divide with no zero lane, `div_err` stays low.
- R8: `done` is high for exactly one cycle. For load and arithmetic it is high 14 clock edges after the edge that accepts `start`. For a store it is high 12 edges after that edge.
- R9: `start` has no effect while an operation is in progress, and it has no effect with operation codes 6 or 7. In both cases there is no memory access, no `done` and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 3 | Operation code: 0 load, 1 store, 2 add, 3 sub, 4 mul, 5 div |
| reg_sel | input | 2 | Register code for load/store: 0 A, 1 S, 2/3 T |
| base_addr | input | ADDR_W | Byte address of lane 0 |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after its address |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide-by-zero flag, valid with `done` |

## Verification
A byte pattern in which every address holds a different value catches lane swaps, byte-order errors and off-by-one stride errors in both load and store. Bases near the top of the address space exercise the wrap. The arithmetic runs are a sweep: an eight-value table that includes zero, one, the largest positive word, the most negative word and minus one is paired across lanes and operations. That sweep separates carry and borrow wrap, product truncation, signed truncating division and the case of the most negative word divided by minus one. In the same sweep, a zero appearing in some divide lanes and not in others checks that a single zero lane blocks the whole update. Unknown operation codes and a second `start` issued in the middle of a store are then shown to leave writes, `done` and register T untouched.

// File: rtl/vecmem_pkg.sv
package vecmem_pkg;

    localparam int VM_LANES      = 4;
    localparam int VM_WORD_BYTES = 3;
    localparam int VM_BYTE_W     = 8;

    typedef enum logic [2:0] {
        VOP_LOAD  = 3'd0,
        VOP_STORE = 3'd1,
        VOP_ADD   = 3'd2,
        VOP_SUB   = 3'd3,
        VOP_MUL   = 3'd4,
        VOP_DIV   = 3'd5
    } vop_e;

    typedef enum logic [1:0] {
        VREG_A = 2'd0,
        VREG_S = 2'd1,
        VREG_T = 2'd2
    } vreg_e;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_READ   = 3'd1,
        SQ_DRAIN  = 3'd2,
        SQ_COMMIT = 3'd3,
        SQ_WRITE  = 3'd4,
        SQ_DONE   = 3'd5
    } sq_state_e;

    typedef struct packed {
        vop_e  op;
        vreg_e dst;
    } vjob_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic vreg_e reg_decode(input logic [1:0] code);
        case (code)
            2'd0:    return VREG_A;
            2'd1:    return VREG_S;
            default: return VREG_T;
        endcase
    endfunction

endpackage

// File: rtl/vm_addr_gen.sv
module vm_addr_gen #(
    parameter int ADDR_W    = 16,
    parameter int VEC_BYTES = 12,
    parameter int IDX_W     = $clog2(VEC_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_in,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);

    logic [ADDR_W-1:0] base_q;

    assign last = (idx == IDX_W'(VEC_BYTES - 1));
    assign addr = base_q + ADDR_W'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            idx    <= '0;
        end else if (arm) begin
            base_q <= base_in;
            idx    <= '0;
        end else if (step && !last) begin
            idx <= idx + 1'b1;
        end
    end

    // R2: byte index advances by one per step within a vector
    assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !last && !arm) |=> idx == $past(idx) + IDX_W'(1));

endmodule

// File: rtl/vm_gather.sv
module vm_gather #(
    parameter int LANES      = 4,
    parameter int WORD_BYTES = 3,
    parameter int BYTE_W     = 8,
    parameter int WORD_W     = WORD_BYTES * BYTE_W,
    parameter int IDX_W      = $clog2(LANES * WORD_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cap,
    input  logic [IDX_W-1:0]             cap_idx,
    input  logic [BYTE_W-1:0]            din,
    output logic [LANES-1:0][WORD_W-1:0] vec
);

    localparam int VEC_BYTES = LANES * WORD_BYTES;

    logic [VEC_BYTES-1:0][BYTE_W-1:0] bytes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
        end else if (cap) begin
            bytes_q[cap_idx] <= din;
        end
    end

    // lowest address of each word lands in the top byte
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            assign vec[l][WORD_W-1-b*BYTE_W -: BYTE_W] = bytes_q[l*WORD_BYTES+b];
        end
    end

endmodule

// File: rtl/vm_lane_alu.sv
module vm_lane_alu
    import vecmem_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 24
) (
    input  vop_e                         op,
    input  logic [LANES-1:0][WORD_W-1:0] acc,
    input  logic [LANES-1:0][WORD_W-1:0] opnd,
    output logic [LANES-1:0][WORD_W-1:0] res,
    output logic                         zero_seen
);

    logic [LANES-1:0] lane_zero;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [WORD_W:0]   sa;
        logic signed [WORD_W:0]   sm;
        logic signed [WORD_W:0]   quo;
        logic        [2*WORD_W-1:0] prod;

        assign lane_zero[l] = (opnd[l] == '0);

        always_comb begin
            sa   = {acc[l][WORD_W-1], acc[l]};
            sm   = {opnd[l][WORD_W-1], opnd[l]};
            prod = (2*WORD_W)'(acc[l]) * (2*WORD_W)'(opnd[l]);
            quo  = lane_zero[l] ? sa : (sa / sm);
            case (op)
                VOP_ADD: res[l] = acc[l] + opnd[l];
                VOP_SUB: res[l] = acc[l] - opnd[l];
                VOP_MUL: res[l] = prod[WORD_W-1:0];
                VOP_DIV: res[l] = quo[WORD_W-1:0];
                default: res[l] = acc[l];
            endcase
        end
    end

    assign zero_seen = |lane_zero;

endmodule

// File: rtl/vm_vreg_file.sv
module vm_vreg_file
    import vecmem_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 24
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  vreg_e                        wsel,
    input  logic [LANES-1:0][WORD_W-1:0] wvec,
    input  vreg_e                        rsel,
    output logic [LANES-1:0][WORD_W-1:0] rvec,
    output logic [LANES-1:0][WORD_W-1:0] avec
);

    localparam int NREG = 3;

    logic [NREG-1:0][LANES-1:0][WORD_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (we) begin
            regs_q[wsel] <= wvec;
        end
    end

    assign rvec = regs_q[rsel];
    assign avec = regs_q[VREG_A];

    // R9: registers only move on a commit
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_q));

endmodule

// File: rtl/vecmem_sequencer.sv
module vecmem_sequencer
    import vecmem_pkg::*;
#(
    parameter int LANES      = VM_LANES,
    parameter int WORD_BYTES = VM_WORD_BYTES,
    parameter int ADDR_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [2:0]           op,
    input  logic [1:0]           reg_sel,
    input  logic [ADDR_W-1:0]    base_addr,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [VM_BYTE_W-1:0] mem_wdata,
    output logic                 mem_we,
    input  logic [VM_BYTE_W-1:0] mem_rdata,
    output logic                 done,
    output logic                 div_err
);

    localparam int BYTE_W    = VM_BYTE_W;
    localparam int WORD_W    = WORD_BYTES * BYTE_W;
    localparam int VEC_BYTES = LANES * WORD_BYTES;
    localparam int IDX_W     = $clog2(VEC_BYTES);

    sq_state_e  state_q;
    vjob_t      job_q;
    logic       err_q;
    logic       rd_pend_q;
    logic [IDX_W-1:0] rd_idx_q;

    logic       accept;
    logic       step;
    logic       last;
    logic [IDX_W-1:0] idx;
    logic       zero_seen;
    logic       reg_we;
    vreg_e      reg_wsel;

    logic [LANES-1:0][WORD_W-1:0] gath_vec;
    logic [LANES-1:0][WORD_W-1:0] alu_vec;
    logic [LANES-1:0][WORD_W-1:0] wr_vec;
    logic [LANES-1:0][WORD_W-1:0] rd_vec;
    logic [LANES-1:0][WORD_W-1:0] va_vec;
    logic [VEC_BYTES-1:0][BYTE_W-1:0] st_bytes;

    assign accept = (state_q == SQ_IDLE) && start && op_known(op);
    assign step   = (state_q == SQ_READ) || (state_q == SQ_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            job_q     <= '{op: VOP_LOAD, dst: VREG_A};
            err_q     <= 1'b0;
            rd_pend_q <= 1'b0;
            rd_idx_q  <= '0;
        end else begin
            rd_pend_q <= (state_q == SQ_READ);
            rd_idx_q  <= idx;
            case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        job_q.op  <= vop_e'(op);
                        job_q.dst <= reg_decode(reg_sel);
                        err_q     <= 1'b0;
                        state_q   <= (vop_e'(op) == VOP_STORE) ? SQ_WRITE : SQ_READ;
                    end
                end
                SQ_READ:   if (last) state_q <= SQ_DRAIN;
                SQ_DRAIN:  state_q <= SQ_COMMIT;
                SQ_COMMIT: begin
                    err_q   <= (job_q.op == VOP_DIV) && zero_seen;
                    state_q <= SQ_DONE;
                end
                SQ_WRITE:  if (last) state_q <= SQ_DONE;
                SQ_DONE:   state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    vm_addr_gen #(
        .ADDR_W    (ADDR_W),
        .VEC_BYTES (VEC_BYTES),
        .IDX_W     (IDX_W)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .arm     (accept),
        .step    (step),
        .base_in (base_addr),
        .addr    (mem_addr),
        .idx     (idx),
        .last    (last)
    );

    vm_gather #(
        .LANES      (LANES),
        .WORD_BYTES (WORD_BYTES),
        .BYTE_W     (BYTE_W),
        .WORD_W     (WORD_W),
        .IDX_W      (IDX_W)
    ) u_gather (
        .clk     (clk),
        .rst     (rst),
        .cap     (rd_pend_q),
        .cap_idx (rd_idx_q),
        .din     (mem_rdata),
        .vec     (gath_vec)
    );

    vm_lane_alu #(
        .LANES  (LANES),
        .WORD_W (WORD_W)
    ) u_alu (
        .op        (job_q.op),
        .acc       (va_vec),
        .opnd      (gath_vec),
        .res       (alu_vec),
        .zero_seen (zero_seen)
    );

    assign reg_we   = (state_q == SQ_COMMIT) && !((job_q.op == VOP_DIV) && zero_seen);
    assign reg_wsel = (job_q.op == VOP_LOAD) ? job_q.dst : VREG_A;
    assign wr_vec   = (job_q.op == VOP_LOAD) ? gath_vec : alu_vec;

    vm_vreg_file #(
        .LANES  (LANES),
        .WORD_W (WORD_W)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (reg_we),
        .wsel (reg_wsel),
        .wvec (wr_vec),
        .rsel (job_q.dst),
        .rvec (rd_vec),
        .avec (va_vec)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_st_lane
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_st_byte
            assign st_bytes[l*WORD_BYTES+b] = rd_vec[l][WORD_W-1-b*BYTE_W -: BYTE_W];
        end
    end

    assign mem_wdata = st_bytes[idx];
    assign mem_we    = (state_q == SQ_WRITE);
    assign done      = (state_q == SQ_DONE);
    assign div_err   = done && err_q;

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the error flag belongs to divides only
    assert_err_div_only_R7: assert property (@(posedge clk) disable iff (rst)
        div_err |-> job_q.op == VOP_DIV);

    // R7: a zero divisor lane leaves A untouched
    assert_div_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_COMMIT && job_q.op == VOP_DIV && zero_seen) |=> $stable(va_vec));

    // R4: memory writes happen only for stores
    assert_we_store_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> job_q.op == VOP_STORE);

    // R2: read addresses are consecutive bytes
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_READ && $past(state_q) == SQ_READ) |->
            mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R9: a start while busy does not alter the running job
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE && start) |=> $stable(job_q));

endmodule

// File: tb/tb_vecmem_sequencer.sv
`timescale 1ns/1ps
module tb_vecmem_sequencer;
    import vecmem_pkg::*;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [1:0]    sel = 2'd0;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata = 8'h00;
    logic          done;
    logic          div_err;

    logic [7:0]  mem [256];
    int          wr_count = 0;
    int          done_count = 0;
    int          checks = 0;
    int          fails = 0;
    logic [23:0] mdl [3][4];
    logic [23:0] vals [8];

    always #4 clk = ~clk;

    vecmem_sequencer #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .reg_sel(sel),
        .base_addr(base), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .done(done), .div_err(div_err)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        mem_rdata <= mem[mem_addr];
        if (done) done_count <= done_count + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int slot(input logic [1:0] s);
        return (s >= 2'd2) ? 2 : int'(s);
    endfunction

    function automatic logic [23:0] rd_word(input int a);
        return {mem[a & 255], mem[(a + 1) & 255], mem[(a + 2) & 255]};
    endfunction

    task automatic poke_word(input int a, input logic [23:0] w);
        mem[a & 255]       = w[23:16];
        mem[(a + 1) & 255] = w[15:8];
        mem[(a + 2) & 255] = w[7:0];
    endtask

    function automatic logic [23:0] ref_op(input int o, input logic [23:0] a, input logic [23:0] m);
        longint sa, sm;
        sa = a[23] ? longint'(a) - 64'sd16777216 : longint'(a);
        sm = m[23] ? longint'(m) - 64'sd16777216 : longint'(m);
        case (o)
            2: return 24'(longint'(a) + longint'(m));
            3: return 24'(longint'(a) - longint'(m));
            4: return 24'(longint'(a) * longint'(m));
            default: return 24'(sa / sm);
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [1:0] s, input logic [AW-1:0] b,
                          input int exp_lat, input logic exp_err, input string req);
        int n;
        int w0;
        @(negedge clk);
        op = o; sel = s; base = b; start = 1'b1; w0 = wr_count;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R8", {req, " latency"}, n, exp_lat);
        chk("R7", {req, " div_err"}, {31'd0, div_err}, {31'd0, exp_err});
        chk("R4", {req, " write count"}, wr_count - w0, (o == 3'd1) ? 12 : 0);
        @(negedge clk);
        chk("R8", {req, " done width"}, {31'd0, done}, 32'd0);
    endtask

    task automatic load_reg(input logic [1:0] s, input int b);
        run_op(3'd0, s, AW'(b), 14, 1'b0, "R3 load");
        for (int l = 0; l < 4; l++) mdl[slot(s)][l] = rd_word(b + 3 * l);
    endtask

    task automatic check_reg(input logic [1:0] s, input int b, input string req);
        run_op(3'd1, s, AW'(b), 12, 1'b0, {req, " store"});
        for (int l = 0; l < 4; l++)
            chk(req, $sformatf("reg %0d lane %0d", slot(s), l), {8'd0, rd_word(b + 3 * l)}, {8'd0, mdl[slot(s)][l]});
    endtask

    initial begin
        int d0;
        int w0;
        logic [7:0] guard_lo;
        logic [7:0] guard_hi;
        logic [23:0] a_v, m_v;
        logic err_exp;

        vals[0] = 24'h000000; vals[1] = 24'h000001; vals[2] = 24'h000002; vals[3] = 24'h7FFFFF;
        vals[4] = 24'h800000; vals[5] = 24'hFFFFFF; vals[6] = 24'h123456; vals[7] = 24'hFEDCBA;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 29 + 7) & 255);
        for (int r = 0; r < 3; r++) for (int l = 0; l < 4; l++) mdl[r][l] = 24'h0;

        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {31'd0, done}, 32'd0);
        chk("R1", "div_err in reset", {31'd0, div_err}, 32'd0);
        chk("R1", "mem_we in reset", {31'd0, mem_we}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done after reset", {31'd0, done}, 32'd0);

        // R1: registers start at zero
        check_reg(2'd0, 8'hC0, "R1");
        check_reg(2'd1, 8'hC0, "R1");
        check_reg(2'd2, 8'hC0, "R1");

        // R3 / R2: loads into each register, checked by stores
        load_reg(2'd0, 8'h00);
        load_reg(2'd1, 8'h10);
        load_reg(2'd3, 8'h20);
        check_reg(2'd0, 8'hC0, "R3");
        check_reg(2'd1, 8'hC0, "R3");
        check_reg(2'd2, 8'hC0, "R3");
        load_reg(2'd2, 8'h30);
        check_reg(2'd0, 8'hC0, "R3");
        check_reg(2'd1, 8'hC0, "R3");
        check_reg(2'd3, 8'hC0, "R3");

        // R2: address wrap on load and store, R4: neighbours untouched
        load_reg(2'd1, 8'hFA);
        guard_lo = mem[8'hFB];
        guard_hi = mem[8'h08];
        check_reg(2'd1, 8'hFC, "R2");
        chk("R4", "byte below store", {24'd0, mem[8'hFB]}, {24'd0, guard_lo});
        chk("R4", "byte above store", {24'd0, mem[8'h08]}, {24'd0, guard_hi});

        // R5 / R6 / R7: arithmetic sweep into A
        for (int o = 2; o <= 5; o++) begin
            for (int p = 0; p < 8; p++) begin
                for (int l = 0; l < 4; l++) begin
                    poke_word(8'hA0 + 3 * l, vals[(p + l) % 8]);
                    poke_word(8'hB0 + 3 * l, vals[(3 * p + l + 1) % 8]);
                end
                load_reg(2'd0, 8'hA0);
                err_exp = 1'b0;
                for (int l = 0; l < 4; l++)
                    if (o == 5 && rd_word(8'hB0 + 3 * l) == 24'h0) err_exp = 1'b1;
                run_op(3'(o), 2'(p % 4), 8'hB0, 14, err_exp, (o == 5) ? "R6 div" : "R5 arith");
                if (!err_exp) begin
                    for (int l = 0; l < 4; l++) begin
                        a_v = mdl[0][l];
                        m_v = rd_word(8'hB0 + 3 * l);
                        mdl[0][l] = ref_op(o, a_v, m_v);
                    end
                end
                check_reg(2'd0, 8'hC0, err_exp ? "R7" : ((o == 5) ? "R6" : "R5"));
            end
        end
        check_reg(2'd1, 8'hC0, "R5");
        check_reg(2'd2, 8'hC0, "R5");

        // R9: unknown codes do nothing
        for (int c = 6; c <= 7; c++) begin
            d0 = done_count; w0 = wr_count;
            @(negedge clk);
            op = 3'(c); sel = 2'd0; base = 8'h00; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (30) @(negedge clk);
            chk("R9", "done for unknown code", done_count - d0, 0);
            chk("R9", "writes for unknown code", wr_count - w0, 0);
        end
        check_reg(2'd0, 8'hC0, "R9");

        // R9: start during a running store is dropped
        d0 = done_count; w0 = wr_count;
        @(negedge clk);
        op = 3'd1; sel = 2'd2; base = 8'hD0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op = 3'd0; sel = 2'd2; base = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R9", "done count with busy start", done_count - d0, 1);
        chk("R9", "writes with busy start", wr_count - w0, 12);
        check_reg(2'd2, 8'hC0, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule